// File: doc/BRIEF.md
# Tagged Capability Memory Controller

This block is a single-port memory controller that keeps a data store and, beside it, a one-bit validity tag for every 64-bit capability granule. It serves four request kinds on one request/response port. Two are ordinary 32-bit data reads and writes with byte enables. The other two are 64-bit capability loads and stores. A valid tag is the proof that a granule holds a genuine capability.

The controller guarantees that plain data traffic can never produce or preserve such proof. Any ordinary write that touches a granule drops its tag. A tag can only be set by a capability store, which writes both words of the granule and the tag in the same clock edge. A capability load returns both words and the tag from the same edge, so no partly updated capability can ever be observed. Capability requests that are not aligned to a granule get an error response and leave memory untouched.

Each accepted request gets its response exactly one clock later. Requests are issued back to back with no stall.

Top module: `tagmem_ctrl`

## Requirements
- R1: Every cycle with `req_valid_i` high produces `rsp_valid_o` high on the next cycle. Cycles without a request produce no response.
- R2: A data read (`req_op_i` = 2'b00) returns the 32-bit word at byte address bits [9:2] on `rsp_rdata_o[31:0]`. Bits [63:32] read as zero, address bits [1:0] are ignored, and `rsp_tag_o` reports the tag of the enclosing granule (address bits [9:3]).
- R3: A data write (2'b01) updates only the byte lanes whose `req_be_i` bit is set, with lane b taking `req_wdata_i[8b+7:8b]`, in the addressed word. All other bytes keep their values.
- R4: A data write with at least one byte enable set clears the tag of its granule, whichever of the granule's two words it targets.
- R5: A data write with all byte enables clear changes neither data nor tag.
- R6: An aligned capability store (2'b11) writes `req_wdata_i[31:0]` to the granule's even word and `req_wdata_i[63:32]` to its odd word. It sets the granule tag to `req_tag_i`, whether that value is 0 or 1.
- R7: An aligned capability load (2'b10) returns the odd word in bits [63:32], the even word in bits [31:0], and the granule tag on `rsp_tag_o`, all taken from the same clock edge.
- R8: A capability load or store whose address bits [2:0] are not all zero responds with `rsp_err_o` high and with zero data and tag, and changes no data and no tag. No other request raises `rsp_err_o`.
- R9: Responses to data writes and capability stores carry zero data and a clear tag.
- R10: After reset every granule tag reads as clear.
- R11: A read in the cycle right after a write to the same location returns the newly written data and tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; clears all tags and the response stage |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 00 data read, 01 data write, 10 capability load, 11 capability store |
| req_addr_i | input | ADDR_W (10) | Byte address |
| req_wdata_i | input | 2*WORD_W (64) | Write data; data writes use the low word |
| req_be_i | input | WORD_W/8 (4) | Byte enables for data writes |
| req_tag_i | input | 1 | Tag to store with a capability |
| rsp_valid_o | output | 1 | Response present |
| rsp_rdata_o | output | 2*WORD_W (64) | Read data |
| rsp_err_o | output | 1 | Misaligned capability request |
| rsp_tag_o | output | 1 | Tag of the granule read |

## Verification
The properties that relate a load to the write one cycle before it assume the request inputs are held low during reset. This keeps the previous-cycle values that they sample well defined. The bench drives every input to zero while reset is asserted and changes inputs only at falling edges.

Data words are not reset, so the bench first writes every word before it compares any read data. Before that point it checks only tags, which are defined from reset. Random traffic is confined to a few granules most of the time, so that back-to-back collisions between data writes and capability operations happen often.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;

   typedef enum logic [1:0] {
      OP_DRD = 2'b00,
      OP_DWR = 2'b01,
      OP_CLD = 2'b10,
      OP_CST = 2'b11
   } tm_op_e;

endpackage

// File: rtl/tagmem_decode.sv
module tagmem_decode
   import tagmem_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned ADDR_W = 10
) (
   input  logic                                 valid_i,
   input  tm_op_e                               op_i,
   input  logic [ADDR_W-1:0]                    addr_i,
   input  logic [WORD_W/8-1:0]                  be_i,
   input  logic                                 tag_i,
   output logic [1:0]                           bank_we_o,
   output logic [1:0][WORD_W/8-1:0]             bank_be_o,
   output logic [ADDR_W-$clog2(WORD_W/8)-2:0]   gidx_o,
   output logic                                 wsel_o,
   output logic                                 tag_we_o,
   output logic                                 tag_val_o,
   output logic                                 err_o
);
   localparam int unsigned BE_W = WORD_W / 8;
   localparam int unsigned WOFF = $clog2(BE_W);
   localparam int unsigned GOFF = WOFF + 1;

   logic misaligned;

   assign gidx_o     = addr_i[ADDR_W-1:GOFF];
   assign wsel_o     = addr_i[WOFF];
   assign misaligned = |addr_i[GOFF-1:0];

   always_comb begin
      bank_we_o = '0;
      bank_be_o = '0;
      tag_we_o  = 1'b0;
      tag_val_o = 1'b0;
      err_o     = valid_i && op_i[1] && misaligned;
      if (valid_i) begin
         unique case (op_i)
            OP_DWR: begin
               bank_we_o[wsel_o] = |be_i;
               bank_be_o[wsel_o] = be_i;
               tag_we_o          = |be_i;
               tag_val_o         = 1'b0;
            end
            OP_CST: begin
               if (!misaligned) begin
                  bank_we_o = 2'b11;
                  bank_be_o = {2{{BE_W{1'b1}}}};
                  tag_we_o  = 1'b1;
                  tag_val_o = tag_i;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/tagmem_word_bank.sv
module tagmem_word_bank #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned DEPTH  = 128
) (
   input  logic                       clk_i,
   input  logic                       re_i,
   input  logic                       we_i,
   input  logic [$clog2(DEPTH)-1:0]   idx_i,
   input  logic [WORD_W/8-1:0]        be_i,
   input  logic [WORD_W-1:0]          wdata_i,
   output logic [WORD_W-1:0]          rdata_o
);
   localparam int unsigned BE_W = WORD_W / 8;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) begin
         for (int b = 0; b < BE_W; b++) begin
            if (be_i[b]) mem[idx_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (re_i) rdata_o <= mem[idx_i];
   end

endmodule

// File: rtl/tagmem_tag_array.sv
module tagmem_tag_array #(
   parameter int unsigned DEPTH = 128
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       we_i,
   input  logic                       wval_i,
   input  logic                       re_i,
   input  logic [$clog2(DEPTH)-1:0]   idx_i,
   output logic                       rbit_o
);
   logic [DEPTH-1:0] tags;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tags <= '0;
      end else if (we_i) begin
         tags[idx_i] <= wval_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rbit_o <= 1'b0;
      end else if (re_i) begin
         rbit_o <= tags[idx_i];
      end
   end

endmodule

// File: rtl/tagmem_ctrl.sv
module tagmem_ctrl
   import tagmem_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned ADDR_W = 10
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   req_valid_i,
   input  logic [1:0]             req_op_i,
   input  logic [ADDR_W-1:0]      req_addr_i,
   input  logic [2*WORD_W-1:0]    req_wdata_i,
   input  logic [WORD_W/8-1:0]    req_be_i,
   input  logic                   req_tag_i,
   output logic                   rsp_valid_o,
   output logic [2*WORD_W-1:0]    rsp_rdata_o,
   output logic                   rsp_err_o,
   output logic                   rsp_tag_o
);
   localparam int unsigned BE_W   = WORD_W / 8;
   localparam int unsigned WOFF   = $clog2(BE_W);
   localparam int unsigned GOFF   = WOFF + 1;
   localparam int unsigned GIDX_W = ADDR_W - GOFF;
   localparam int unsigned NGRAN  = 1 << GIDX_W;

   if (WORD_W < 8 || (WORD_W % 8) != 0) begin : g_bad_word
      $error("WORD_W must be a nonzero multiple of 8");
   end
   if ((BE_W & (BE_W - 1)) != 0) begin : g_bad_lanes
      $error("WORD_W/8 must be a power of two");
   end
   if (ADDR_W <= GOFF) begin : g_bad_addr
      $error("ADDR_W too small to hold one granule index bit");
   end

   tm_op_e                    op;
   logic [1:0]                bank_we;
   logic [1:0][BE_W-1:0]      bank_be;
   logic [GIDX_W-1:0]         gidx;
   logic                      wsel;
   logic                      tag_we;
   logic                      tag_val;
   logic                      dec_err;
   logic                      rd_en;
   logic [WORD_W-1:0]         bank_rd [2];
   logic                      tag_rd;

   tm_op_e                    rsp_op_q;
   logic                      rsp_valid_q;
   logic                      rsp_err_q;
   logic                      rsp_wsel_q;

   assign op    = tm_op_e'(req_op_i);
   assign rd_en = req_valid_i && !req_op_i[0];

   tagmem_decode #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W)
   ) u_decode (
      .valid_i   (req_valid_i),
      .op_i      (op),
      .addr_i    (req_addr_i),
      .be_i      (req_be_i),
      .tag_i     (req_tag_i),
      .bank_we_o (bank_we),
      .bank_be_o (bank_be),
      .gidx_o    (gidx),
      .wsel_o    (wsel),
      .tag_we_o  (tag_we),
      .tag_val_o (tag_val),
      .err_o     (dec_err)
   );

   for (genvar g = 0; g < 2; g++) begin : g_bank
      logic [WORD_W-1:0] wdata;
      assign wdata = req_op_i[1] ? req_wdata_i[g*WORD_W +: WORD_W]
                                 : req_wdata_i[WORD_W-1:0];
      tagmem_word_bank #(
         .WORD_W (WORD_W),
         .DEPTH  (NGRAN)
      ) u_bank (
         .clk_i   (clk_i),
         .re_i    (rd_en),
         .we_i    (bank_we[g]),
         .idx_i   (gidx),
         .be_i    (bank_be[g]),
         .wdata_i (wdata),
         .rdata_o (bank_rd[g])
      );
   end

   tagmem_tag_array #(
      .DEPTH (NGRAN)
   ) u_tags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (tag_we),
      .wval_i (tag_val),
      .re_i   (rd_en),
      .idx_i  (gidx),
      .rbit_o (tag_rd)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_q <= 1'b0;
         rsp_op_q    <= OP_DRD;
         rsp_err_q   <= 1'b0;
         rsp_wsel_q  <= 1'b0;
      end else begin
         rsp_valid_q <= req_valid_i;
         rsp_op_q    <= op;
         rsp_err_q   <= dec_err;
         rsp_wsel_q  <= wsel;
      end
   end

   always_comb begin
      rsp_valid_o = rsp_valid_q;
      rsp_err_o   = rsp_valid_q && rsp_err_q;
      rsp_rdata_o = '0;
      rsp_tag_o   = 1'b0;
      if (rsp_valid_q && !rsp_err_q) begin
         unique case (rsp_op_q)
            OP_DRD: begin
               rsp_rdata_o = {{WORD_W{1'b0}}, bank_rd[rsp_wsel_q]};
               rsp_tag_o   = tag_rd;
            end
            OP_CLD: begin
               rsp_rdata_o = {bank_rd[1], bank_rd[0]};
               rsp_tag_o   = tag_rd;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/tagmem_ctrl_chk.sv
module tagmem_ctrl_chk #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned ADDR_W = 10
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   req_valid_i,
   input logic [1:0]             req_op_i,
   input logic [ADDR_W-1:0]      req_addr_i,
   input logic [2*WORD_W-1:0]    req_wdata_i,
   input logic [WORD_W/8-1:0]    req_be_i,
   input logic                   req_tag_i,
   input logic                   rsp_valid_o,
   input logic [2*WORD_W-1:0]    rsp_rdata_o,
   input logic                   rsp_err_o,
   input logic                   rsp_tag_o
);
   localparam int unsigned GOFF = $clog2(WORD_W / 8) + 1;

   logic [ADDR_W-GOFF-1:0] gran;
   logic                   aligned;
   logic                   is_dwr;
   logic                   is_cld;
   logic                   is_cst;

   assign gran    = req_addr_i[ADDR_W-1:GOFF];
   assign aligned = req_addr_i[GOFF-1:0] == '0;
   assign is_dwr  = req_valid_i && req_op_i == 2'b01;
   assign is_cld  = req_valid_i && req_op_i == 2'b10;
   assign is_cst  = req_valid_i && req_op_i == 2'b11;

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> rsp_valid_o);

   // R1
   no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> !rsp_valid_o);

   // R8
   misaligned_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_op_i[1] && !aligned) |=> (rsp_err_o && rsp_rdata_o == '0 && !rsp_tag_o));

   // R8
   err_only_misaligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && (!req_op_i[1] || aligned)) |=> !rsp_err_o);

   // R9
   write_rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_op_i[0]) |=> (rsp_rdata_o == '0 && !rsp_tag_o));

   // R4
   dwr_clears_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_cld && aligned && $past(is_dwr && (|req_be_i)) && $past(gran) == gran) |=> !rsp_tag_o);

   // R11
   cst_tag_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_cld && aligned && $past(is_cst && aligned) && $past(gran) == gran)
      |=> (rsp_tag_o == $past(req_tag_i, 2) && rsp_rdata_o == $past(req_wdata_i, 2)));

endmodule

bind tagmem_ctrl tagmem_ctrl_chk #(
   .WORD_W (WORD_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .req_valid_i (req_valid_i),
   .req_op_i    (req_op_i),
   .req_addr_i  (req_addr_i),
   .req_wdata_i (req_wdata_i),
   .req_be_i    (req_be_i),
   .req_tag_i   (req_tag_i),
   .rsp_valid_o (rsp_valid_o),
   .rsp_rdata_o (rsp_rdata_o),
   .rsp_err_o   (rsp_err_o),
   .rsp_tag_o   (rsp_tag_o)
);

// File: tb/tb_tagmem_ctrl.sv
module tb_tagmem_ctrl;
   localparam int NWORDS = 256;
   localparam int NGRAN  = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [9:0]  req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        req_tag = 1'b0;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic        rsp_err;
   logic        rsp_tag;

   always #4 clk = ~clk;

   tagmem_ctrl #(.WORD_W(32), .ADDR_W(10)) dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_valid_i (req_valid),
      .req_op_i    (req_op),
      .req_addr_i  (req_addr),
      .req_wdata_i (req_wdata),
      .req_be_i    (req_be),
      .req_tag_i   (req_tag),
      .rsp_valid_o (rsp_valid),
      .rsp_rdata_o (rsp_rdata),
      .rsp_err_o   (rsp_err),
      .rsp_tag_o   (rsp_tag)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [31:0] m_word [NWORDS];
   bit          m_tag  [NGRAN];

   bit          e_valid = 1'b0;
   bit          e_err;
   bit          e_tag;
   logic [63:0] e_data;
   string       e_req = "R1";

   task automatic compare();
      checks++;
      if (rsp_valid !== e_valid) begin
         errors++;
         $display("FAIL %s valid actual=%b expected=%b", e_req, rsp_valid, e_valid);
      end
      if (e_valid) begin
         checks++;
         if (rsp_err !== e_err) begin
            errors++;
            $display("FAIL %s err actual=%b expected=%b", e_req, rsp_err, e_err);
         end
         checks++;
         if (rsp_tag !== e_tag) begin
            errors++;
            $display("FAIL %s tag actual=%b expected=%b", e_req, rsp_tag, e_tag);
         end
         if (^e_data !== 1'bx) begin
            checks++;
            if (rsp_rdata !== e_data) begin
               errors++;
               $display("FAIL %s data actual=%h expected=%h", e_req, rsp_rdata, e_data);
            end
         end
      end
   endtask

   task automatic cycle(input bit v, input logic [1:0] op, input int addr,
                        input logic [63:0] wd, input logic [3:0] be, input bit tg,
                        input string rq);
      int w, g;
      bit al;
      @(negedge clk);
      compare();
      req_valid = v;
      req_op    = op;
      req_addr  = addr[9:0];
      req_wdata = wd;
      req_be    = be;
      req_tag   = tg;
      w  = (addr >> 2) % NWORDS;
      g  = (addr >> 3) % NGRAN;
      al = (addr % 8) == 0;
      e_valid = v;
      e_err   = 1'b0;
      e_tag   = 1'b0;
      e_data  = '0;
      e_req   = rq;
      if (v) begin
         case (op)
            2'b00: begin
               e_data = {32'h0, m_word[w]};
               e_tag  = m_tag[g];
            end
            2'b01: begin
               for (int b = 0; b < 4; b++)
                  if (be[b]) m_word[w][8*b +: 8] = wd[8*b +: 8];
               if (be != 4'b0) m_tag[g] = 1'b0;
            end
            2'b10: begin
               if (!al) e_err = 1'b1;
               else begin
                  e_data = {m_word[2*g+1], m_word[2*g]};
                  e_tag  = m_tag[g];
               end
            end
            default: begin
               if (!al) e_err = 1'b1;
               else begin
                  m_word[2*g]   = wd[31:0];
                  m_word[2*g+1] = wd[63:32];
                  m_tag[g]      = tg;
               end
            end
         endcase
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NWORDS; i++) m_word[i] = 'x;
      for (int i = 0; i < NGRAN; i++) m_tag[i] = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: tags clear after reset, R1: idle gives no response
      cycle(0, 2'b00, 0, 0, 0, 0, "R1");
      cycle(1, 2'b10, 0, 0, 0, 0, "R10");
      cycle(1, 2'b10, 5*8, 0, 0, 0, "R10");
      cycle(1, 2'b10, 127*8, 0, 0, 0, "R10");
      cycle(0, 2'b00, 0, 0, 0, 0, "R1");

      // R3: fill every word with full-lane writes
      for (int i = 0; i < NWORDS; i++)
         cycle(1, 2'b01, i*4, {32'h0, 32'hA500_0000 ^ (i * 32'h0101_0101)}, 4'hF, 0, "R3");

      // R2: data reads, low address bits ignored
      cycle(1, 2'b00, 12, 0, 0, 0, "R2");
      cycle(1, 2'b00, 19, 0, 0, 0, "R2");
      cycle(1, 2'b00, 1022, 0, 0, 0, "R2");

      // R6 / R7 / R11: store then load at once
      cycle(1, 2'b11, 3*8, 64'h1122_3344_5566_7788, 0, 1, "R6");
      cycle(1, 2'b10, 3*8, 0, 0, 0, "R11");
      cycle(1, 2'b10, 3*8, 0, 0, 0, "R7");
      // R2: data read of a tagged granule reports the tag
      cycle(1, 2'b00, 3*8+4, 0, 0, 0, "R2");

      // R4 / R3: partial write to odd word clears tag, merges byte
      cycle(1, 2'b01, 3*8+4, 64'h0000_0000_00EE_0000, 4'b0100, 0, "R4");
      cycle(1, 2'b10, 3*8, 0, 0, 0, "R4");

      // R5: zero byte enables change nothing
      cycle(1, 2'b11, 4*8, 64'hCAFE_0001_BEEF_0002, 0, 1, "R6");
      cycle(1, 2'b01, 4*8, 64'h0000_0000_FFFF_FFFF, 4'b0000, 0, "R5");
      cycle(1, 2'b10, 4*8, 0, 0, 0, "R5");

      // R8: misaligned capability operations
      cycle(1, 2'b11, 6*8+4, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, "R8");
      cycle(1, 2'b10, 6*8, 0, 0, 0, "R8");
      cycle(1, 2'b10, 6*8+2, 0, 0, 0, "R8");
      cycle(1, 2'b00, 6*8+4, 0, 0, 0, "R8");

      // R6: storing a clear tag over a tagged granule
      cycle(1, 2'b11, 9*8, 64'h0123_4567_89AB_CDEF, 0, 1, "R6");
      cycle(1, 2'b11, 9*8, 64'h0F0F_0F0F_F0F0_F0F0, 0, 0, "R6");
      cycle(1, 2'b10, 9*8, 0, 0, 0, "R6");
      // R9: write responses quiet
      cycle(1, 2'b01, 9*8, 64'h1, 4'h1, 0, "R9");
      cycle(0, 2'b00, 0, 0, 0, 0, "R9");

      // random mix: R3 R4 R6 R7 R8 R11
      for (int i = 0; i < 4000; i++) begin
         bit          v;
         logic [1:0]  op;
         int          a;
         v  = ($urandom % 4) != 0;
         op = 2'($urandom % 4);
         a  = ($urandom % 2) ? int'($urandom % 64) : int'($urandom % 1024);
         if (op[1] && ($urandom % 8) != 0) a = a & ~7;
         cycle(v, op, a, {$urandom, $urandom}, 4'($urandom % 16), 1'($urandom % 2),
               "R11 mix R4 R6 R7 R8");
      end
      cycle(0, 2'b00, 0, 0, 0, 0, "R1");
      cycle(0, 2'b00, 0, 0, 0, 0, "R1");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule